// File: doc/BRIEF.md
# PS/2 Host Port with Status and Interrupt

The block is the host side of a two-wire PS/2 link. It watches the clock and data lines and assembles the frames that a keyboard or mouse sends. Each good byte goes into a scan-code holding register. If a second byte arrives before software has serviced the first, the second byte goes into the upper half of that register and a flag records that it is there. Frames with a bad parity or stop bit are dropped without any trace.

Software sends a command by writing a byte to the command location. The block then holds the clock low to inhibit the device and pulls data low to request a transfer. It shifts the byte, an odd parity bit and a stop bit out on the device's clock. It then samples the device's acknowledge bit and reports completion, with or without error, in sticky status bits. A single interrupt line reflects the pending receive and transmit events. Both wires use open-drain control: the block only ever pulls a line low or releases it, and it reads the line levels back through a synchronizer and glitch filter.

Register map (word select `reg_addr`): 0 = command (write only, bits 7:0 are the byte to send). 1 = status. 2 = scan code (bits 7:0 hold the first byte, bits 15:8 the second). Any other select reads zero.

Top module: `ps2_host_port`

## Requirements
- R1: A valid device frame (start 0, eight data bits LSB first, odd parity, stop 1) that completes while status bit 0 is clear stores its byte in scan-code bits 7:0, clears bits 15:8, and sets status bit 0.
- R2: A valid frame that completes while status bit 0 is set and bit 1 is clear stores its byte in scan-code bits 15:8 and sets status bit 1. A frame that completes while both bits are set is dropped and leaves the scan-code register unchanged. Bit 1 is never set while bit 0 is clear.
- R3: Writing status with bit 0 at 1 clears bits 0 and 1. Writing with bit 0 at 0 leaves them unchanged.
- R4: A frame whose parity bit is not odd, or whose stop bit is 0, changes neither the status nor the scan-code register.
- R5: A command write made while the block is idle holds the clock line low for INHIBIT_CYCLES cycles with data released. It then pulls data low and releases the clock. On the next nine device clock falling edges it puts out the eight data bits LSB first and then odd parity. It releases data on the tenth falling edge and samples the acknowledge on the eleventh. It then sets status bit 4.
- R6: If data is high at the acknowledge sample, status bit 5 is set together with bit 4. Bit 5 is never set while bit 4 is clear.
- R7: An accepted command write clears status bit 5 at once. Writing status with bit 5 at 1 clears bit 5. Writing with bit 4 at 1 clears bits 4 and 5.
- R8: After reset the status and scan-code registers read zero and both lines are released. Status bits 2, 3, 6 and 7 and all upper bits always read zero.
- R9: `irq` is high exactly when status bit 0 or status bit 4 is set.
- R10: If no clock falling edge arrives for TIMEOUT_CYCLES cycles inside a frame, the frame is abandoned and the block returns to idle. An abandoned receive changes no register. An abandoned transmit releases both lines and sets status bits 4 and 5.
- R11: A command write made while a transfer is in progress is ignored, and the byte already being sent is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 scan code |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| ps2_clk_in | input | 1 | Level sampled on the PS/2 clock wire |
| ps2_dat_in | input | 1 | Level sampled on the PS/2 data wire |
| ps2_clk_pull_low | output | 1 | 1 pulls the clock wire low, 0 releases it |
| ps2_dat_pull_low | output | 1 | 1 pulls the data wire low, 0 releases it |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FILT_LEN = 2, INHIBIT_CYCLES = 40 and TIMEOUT_CYCLES = 400, in place of defaults sized for microseconds and milliseconds. A device clock half-period of 20 system cycles still clears the filter easily. The short inhibit makes it cheap to measure the hold time exactly, and to land a second command write inside it. The short timeout lets both the receive and transmit abort paths run, and lets a following frame show that the block returned to idle.

// File: rtl/ps2_host_pkg.sv
// Package: shared types and constants of the PS/2 host port.
// Assumes a 2-bit word select and an 8-bit status field.
package ps2_host_pkg;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_RX      = 2'd1,
        ENG_TX_HOLD = 2'd2,
        ENG_TX_SHIFT = 2'd3
    } eng_state_t;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_SCAN = 2'd2;

    localparam int BIT_RX_PEND  = 0;
    localparam int BIT_RX_TWO   = 1;
    localparam int BIT_TX_DONE  = 4;
    localparam int BIT_TX_ERR   = 5;

    // Bits of the status write that act as clear-by-one.
    localparam logic [7:0] STAT_W1C_MASK = 8'b0011_0001;

    localparam int FRAME_LAST_RX = 9;   // index of the stop bit count
    localparam int FRAME_LAST_TX = 10;  // index of the acknowledge count

endpackage

// File: rtl/ps2_line_filter.sv
// Module: synchronizer and glitch filter for WIDTH asynchronous lines.
// Each line goes through SYNC_STAGES flops. The filtered output then follows
// the synchronized level only after that level has differed from the output
// for FILT_LEN consecutive cycles. Lines idle high (open-drain pull-up).
module ps2_line_filter #(
    parameter int WIDTH       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_in,
    output logic [WIDTH-1:0] line_out
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sync_q;
        logic [CNT_W-1:0]       cnt_q;
        logic                   out_q;

        // Bring the raw line into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in[g]};
        end

        // Accept a new level only once it has stayed put for FILT_LEN cycles.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
                out_q <= 1'b1;
            end else if (sync_q[SYNC_STAGES-1] != out_q) begin
                if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                    out_q <= sync_q[SYNC_STAGES-1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end

        assign line_out[g] = out_q;
    end

endmodule

// File: rtl/ps2_frame_engine.sv
// Module: PS/2 frame engine, one transfer at a time in either direction.
// Receives 11-bit device frames on falling edges of the filtered clock and
// runs host-to-device commands: inhibit, request, shift, acknowledge sample.
// A watchdog abandons a frame whose clock stops. Assumes filtered inputs.
module ps2_frame_engine
    import ps2_host_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 10000,
    parameter int TIMEOUT_CYCLES = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clk_f,
    input  logic       dat_f,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic       cmd_accept,
    output logic       clk_pull_low,
    output logic       dat_pull_low,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_done,
    output logic       tx_nack
);
    localparam int TMR_MAX = (INHIBIT_CYCLES > TIMEOUT_CYCLES) ? INHIBIT_CYCLES : TIMEOUT_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] HOLD_END = TMR_W'(INHIBIT_CYCLES - 1);
    localparam logic [TMR_W-1:0] WDOG_END = TMR_W'(TIMEOUT_CYCLES - 1);

    eng_state_t       state_q;
    logic [3:0]       bit_cnt_q;
    logic [8:0]       shreg_q;
    logic [TMR_W-1:0] tmr_q;
    logic             clk_f_d;
    logic             fall;

    // Remember the last filtered clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_f_d <= 1'b1;
        else        clk_f_d <= clk_f;
    end

    assign fall = clk_f_d & ~clk_f;

    // A command is taken only when idle and no completion is being reported.
    assign cmd_accept = cmd_wr && (state_q == ENG_IDLE) && !tx_done;

    // Frame sequencing for both directions, including the watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ENG_IDLE;
            bit_cnt_q    <= '0;
            shreg_q      <= '0;
            tmr_q        <= '0;
            clk_pull_low <= 1'b0;
            dat_pull_low <= 1'b0;
            rx_valid     <= 1'b0;
            rx_byte      <= '0;
            tx_done      <= 1'b0;
            tx_nack      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_done  <= 1'b0;
            unique case (state_q)
                ENG_IDLE: begin
                    tmr_q     <= '0;
                    bit_cnt_q <= '0;
                    if (cmd_accept) begin
                        shreg_q      <= {~^cmd_byte, cmd_byte};
                        clk_pull_low <= 1'b1;
                        state_q      <= ENG_TX_HOLD;
                    end else if (fall && !dat_f) begin
                        state_q <= ENG_RX;
                    end
                end
                ENG_RX: begin
                    if (fall) begin
                        tmr_q <= '0;
                        if (bit_cnt_q == 4'(FRAME_LAST_RX)) begin
                            rx_valid <= (^shreg_q) && dat_f;
                            rx_byte  <= shreg_q[7:0];
                            state_q  <= ENG_IDLE;
                        end else begin
                            shreg_q   <= {dat_f, shreg_q[8:1]};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end else if (tmr_q == WDOG_END) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ENG_TX_HOLD: begin
                    if (tmr_q == HOLD_END) begin
                        clk_pull_low <= 1'b0;
                        dat_pull_low <= 1'b1;
                        tmr_q        <= '0;
                        state_q      <= ENG_TX_SHIFT;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ENG_TX_SHIFT: begin
                    if (fall) begin
                        tmr_q <= '0;
                        if (bit_cnt_q < 4'(FRAME_LAST_RX)) begin
                            dat_pull_low <= ~shreg_q[0];
                            shreg_q      <= {1'b0, shreg_q[8:1]};
                            bit_cnt_q    <= bit_cnt_q + 1'b1;
                        end else if (bit_cnt_q == 4'(FRAME_LAST_RX)) begin
                            dat_pull_low <= 1'b0;
                            bit_cnt_q    <= bit_cnt_q + 1'b1;
                        end else begin
                            tx_done <= 1'b1;
                            tx_nack <= dat_f;
                            state_q <= ENG_IDLE;
                        end
                    end else if (tmr_q == WDOG_END) begin
                        tx_done      <= 1'b1;
                        tx_nack      <= 1'b1;
                        dat_pull_low <= 1'b0;
                        clk_pull_low <= 1'b0;
                        state_q      <= ENG_IDLE;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    AST_HOLD_DRIVES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_TX_HOLD) |-> (clk_pull_low && !dat_pull_low)); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENG_IDLE) |-> (!clk_pull_low && !dat_pull_low)); // R10
    AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ENG_RX) || (state_q == ENG_TX_SHIFT)) |-> (tmr_q <= WDOG_END)); // R10
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (state_q == ENG_IDLE)); // R5
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && state_q == ENG_TX_HOLD) |=> $stable(shreg_q)); // R11

endmodule

// File: rtl/ps2_status_regs.sv
// Module: status, scan-code and interrupt registers of the PS/2 host port.
// Takes completion pulses from the frame engine and software accesses.
// A new event wins over a clear written in the same cycle.
module ps2_status_regs
    import ps2_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wdata,
    input  logic        cmd_accept,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_done,
    input  logic        tx_nack,
    output logic [15:0] reg_rdata,
    output logic        irq
);
    logic        rx_pend_q;
    logic        rx_two_q;
    logic        tx_done_q;
    logic        tx_err_q;
    logic [15:0] scan_q;
    logic [7:0]  w1c;
    logic [7:0]  status_word;

    assign w1c = (reg_wr_en && reg_addr == SEL_STAT) ? (reg_wdata & STAT_W1C_MASK) : 8'h00;

    // Receive side: first byte low, second byte high, later bytes dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pend_q <= 1'b0;
            rx_two_q  <= 1'b0;
            scan_q    <= '0;
        end else if (rx_valid && !rx_pend_q) begin
            scan_q    <= {8'h00, rx_byte};
            rx_pend_q <= 1'b1;
            rx_two_q  <= 1'b0;
        end else if (rx_valid && !rx_two_q) begin
            scan_q[15:8] <= rx_byte;
            rx_two_q     <= 1'b1;
        end else if (w1c[BIT_RX_PEND]) begin
            rx_pend_q <= 1'b0;
            rx_two_q  <= 1'b0;
        end
    end

    // Transmit side: completion and error, with the error cleared on a new command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done_q <= 1'b0;
            tx_err_q  <= 1'b0;
        end else if (tx_done) begin
            tx_done_q <= 1'b1;
            tx_err_q  <= tx_nack;
        end else begin
            if (w1c[BIT_TX_DONE]) begin
                tx_done_q <= 1'b0;
                tx_err_q  <= 1'b0;
            end
            if (w1c[BIT_TX_ERR] || cmd_accept) tx_err_q <= 1'b0;
        end
    end

    // Status layout.
    always_comb begin
        status_word              = 8'h00;
        status_word[BIT_RX_PEND] = rx_pend_q;
        status_word[BIT_RX_TWO]  = rx_two_q;
        status_word[BIT_TX_DONE] = tx_done_q;
        status_word[BIT_TX_ERR]  = tx_err_q;
    end

    // Read multiplexer.
    always_comb begin
        unique case (reg_addr)
            SEL_STAT: reg_rdata = {8'h00, status_word};
            SEL_SCAN: reg_rdata = scan_q;
            default:  reg_rdata = 16'h0000;
        endcase
    end

    assign irq = rx_pend_q | tx_done_q;

    AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_two_q |-> rx_pend_q); // R2
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_q |-> tx_done_q); // R6
    AST_CMD_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> !tx_err_q); // R7
    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[BIT_RX_PEND] && !rx_valid) |=> (!rx_pend_q && !rx_two_q)); // R3
    AST_DROP_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_two_q) |=> $stable(scan_q)); // R2

endmodule

// File: rtl/ps2_host_port.sv
// Module: top of the PS/2 host port.
// Filters the two wires, runs the frame engine, and holds the software-visible
// registers. Assumes open-drain wires with external pull-ups; the pull-low
// outputs drive those wires.
module ps2_host_port
    import ps2_host_pkg::*;
#(
    parameter int FILT_LEN       = 8,
    parameter int INHIBIT_CYCLES = 10000,
    parameter int TIMEOUT_CYCLES = 200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        ps2_clk_in,
    input  logic        ps2_dat_in,
    output logic        ps2_clk_pull_low,
    output logic        ps2_dat_pull_low,
    output logic        irq
);
    logic [1:0] lines_f;
    logic       cmd_wr;
    logic       cmd_accept;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       tx_done;
    logic       tx_nack;

    assign cmd_wr = reg_wr_en && (reg_addr == SEL_CMD);

    ps2_line_filter #(
        .WIDTH      (2),
        .SYNC_STAGES(2),
        .FILT_LEN   (FILT_LEN)
    ) filt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in ({ps2_dat_in, ps2_clk_in}),
        .line_out(lines_f)
    );

    ps2_frame_engine #(
        .INHIBIT_CYCLES(INHIBIT_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_f       (lines_f[0]),
        .dat_f       (lines_f[1]),
        .cmd_wr      (cmd_wr),
        .cmd_byte    (reg_wdata),
        .cmd_accept  (cmd_accept),
        .clk_pull_low(ps2_clk_pull_low),
        .dat_pull_low(ps2_dat_pull_low),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_done     (tx_done),
        .tx_nack     (tx_nack)
    );

    ps2_status_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .cmd_accept(cmd_accept),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_done   (tx_done),
        .tx_nack   (tx_nack),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    AST_IRQ_FOLLOWS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> irq); // R9

endmodule

// File: tb/ps2_host_port_tb.sv
// Bench: device model on open-drain wires, table-driven receive cases,
// then directed tests for two-byte hold, clears, transmit and watchdog.
module ps2_host_port_tb_top;

    localparam int FILT  = 2;
    localparam int INH   = 40;
    localparam int TOUT  = 400;
    localparam int HALF  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [15:0] reg_rdata;
    logic        clk_pl, dat_pl, irq;
    logic        dev_clk = 1'b1;
    logic        dev_dat = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    ps2_host_port #(
        .FILT_LEN      (FILT),
        .INHIBIT_CYCLES(INH),
        .TIMEOUT_CYCLES(TOUT)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_addr        (reg_addr),
        .reg_wr_en       (reg_wr_en),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .ps2_clk_in      (dev_clk & ~clk_pl),
        .ps2_dat_in      (dev_dat & ~dat_pl),
        .ps2_clk_pull_low(clk_pl),
        .ps2_dat_pull_low(dat_pl),
        .irq             (irq)
    );

    // Receive vectors: {byte, flip parity, bad stop, expect accepted}
    localparam int NVEC = 8;
    localparam logic [10:0] RX_VEC [NVEC] = '{
        {8'h1C, 1'b0, 1'b0, 1'b1},
        {8'hF0, 1'b0, 1'b0, 1'b1},
        {8'h00, 1'b0, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 1'b1},
        {8'h5A, 1'b1, 1'b0, 1'b0},
        {8'h33, 1'b0, 1'b1, 1'b0},
        {8'h80, 1'b0, 1'b0, 1'b1},
        {8'hA5, 1'b1, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    // Device sends a frame; nbits < 11 stops early to leave a partial frame.
    task automatic send_frame(input logic [7:0] b, input logic flip_par,
                              input logic bad_stop, input int nbits);
        logic [10:0] bits;
        bits = {~bad_stop, (~^b) ^ flip_par, b, 1'b0};
        for (int i = 0; i < nbits; i++) begin
            dev_dat = bits[i];
            wait_cyc(HALF);
            dev_clk = 1'b0;
            wait_cyc(HALF);
            dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    // Device side of a host command: measures hold, clocks in 10 bits, acks.
    task automatic dev_serve(input logic ack, output logic [9:0] got,
                             output int hold, output logic req_ok);
        hold = 0;
        got  = '0;
        while (!clk_pl) @(negedge clk);
        while (clk_pl) begin @(negedge clk); hold++; end
        req_ok = dat_pl;
        wait_cyc(HALF);
        for (int i = 0; i < 10; i++) begin
            dev_clk = 1'b0;
            wait_cyc(HALF);
            got[i] = dev_dat & ~dat_pl;
            dev_clk = 1'b1;
            wait_cyc(HALF);
        end
        if (ack) dev_dat = 1'b0;
        dev_clk = 1'b0;
        wait_cyc(HALF);
        dev_clk = 1'b1;
        dev_dat = 1'b1;
        wait_cyc(2 * HALF);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int v;
        logic [9:0] got;
        int hold;
        logic req_ok;

        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R8: reset state
        reg_read(2'd1, v); check("R8 status reset", v, 0);
        reg_read(2'd2, v); check("R8 scan reset", v, 0);
        reg_read(2'd3, v); check("R8 unused select", v, 0);
        check("R8 lines released", {30'd0, clk_pl, dat_pl}, 0);
        check("R9 irq at reset", int'(irq), 0);

        // R1 R4: receive vector table
        foreach (RX_VEC[k]) begin
            reg_write(2'd1, 8'hFF);
            send_frame(RX_VEC[k][10:3], RX_VEC[k][2], RX_VEC[k][1], 11);
            reg_read(2'd1, v);
            check(RX_VEC[k][0] ? "R1 status after good frame" : "R4 status after bad frame",
                  v, RX_VEC[k][0] ? 1 : 0);
            check("R9 irq with receive", int'(irq), RX_VEC[k][0] ? 1 : 0);
            if (RX_VEC[k][0]) begin
                reg_read(2'd2, v);
                check("R1 scan low byte", v, int'(RX_VEC[k][10:3]));
            end
        end
        reg_write(2'd1, 8'hFF);

        // R4: dropped frame leaves the held byte alone
        send_frame(8'h21, 1'b0, 1'b0, 11);
        send_frame(8'h44, 1'b1, 1'b0, 11);
        reg_read(2'd2, v); check("R4 scan kept after bad frame", v, 16'h0021);
        reg_read(2'd1, v); check("R4 status kept after bad frame", v, 1);
        reg_write(2'd1, 8'h01);

        // R2: two bytes, then a third dropped
        send_frame(8'h12, 1'b0, 1'b0, 11);
        send_frame(8'h34, 1'b0, 1'b0, 11);
        reg_read(2'd2, v); check("R2 two bytes", v, 16'h3412);
        reg_read(2'd1, v); check("R2 R8 status two bytes", v, 3);
        send_frame(8'h56, 1'b0, 1'b0, 11);
        reg_read(2'd2, v); check("R2 third dropped", v, 16'h3412);

        // R3: write zero does nothing, write one clears both bits
        reg_write(2'd1, 8'hFE);
        reg_read(2'd1, v); check("R3 write zero keeps", v, 3);
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, v); check("R3 clear", v, 0);
        check("R9 irq after clear", int'(irq), 0);

        // R5 R11: command with ack; second write during hold ignored
        fork
            dev_serve(1'b1, got, hold, req_ok);
            begin
                reg_write(2'd0, 8'hED);
                wait_cyc(10);
                reg_write(2'd0, 8'hAA);
            end
        join
        check("R5 hold length", hold, INH);
        check("R5 data pulled at release", int'(req_ok), 1);
        check("R11 R5 byte sent", int'(got[7:0]), 8'hED);
        check("R5 odd parity", int'(got[8]), int'(~^8'hED));
        check("R5 stop released", int'(got[9]), 1);
        reg_read(2'd1, v); check("R5 done no error", v, 16'h10);
        check("R9 irq with transmit", int'(irq), 1);
        reg_write(2'd1, 8'h10);
        reg_read(2'd1, v); check("R7 clear done", v, 0);

        // R6: no acknowledge
        fork
            dev_serve(1'b0, got, hold, req_ok);
            reg_write(2'd0, 8'h55);
        join
        check("R6 byte sent", int'(got[7:0]), 8'h55);
        reg_read(2'd1, v); check("R6 error with done", v, 16'h30);

        // R7: clear error alone by writing one
        reg_write(2'd1, 8'h20);
        reg_read(2'd1, v); check("R7 clear error only", v, 16'h10);

        // R7: a new command clears a pending error at once
        fork
            dev_serve(1'b0, got, hold, req_ok);
            reg_write(2'd0, 8'h11);
        join
        reg_read(2'd1, v); check("R6 error again", v, 16'h30);
        fork
            dev_serve(1'b1, got, hold, req_ok);
            begin
                reg_write(2'd0, 8'hF4);
                reg_read(2'd1, v);
                check("R7 error cleared on command", v, 16'h10);
            end
        join
        check("R5 byte F4", int'(got[7:0]), 8'hF4);
        reg_read(2'd1, v); check("R5 done after ack", v, 16'h10);
        reg_write(2'd1, 8'h30);

        // R10: partial receive abandoned, then a full frame accepted
        send_frame(8'h6B, 1'b0, 1'b0, 4);
        wait_cyc(TOUT + 50);
        reg_read(2'd1, v); check("R10 partial frame ignored", v, 0);
        send_frame(8'h77, 1'b0, 1'b0, 11);
        reg_read(2'd2, v); check("R10 idle after abort", v, 16'h0077);
        reg_write(2'd1, 8'h01);

        // R10: transmit with a silent device
        reg_write(2'd0, 8'h99);
        wait_cyc(INH + TOUT + 50);
        reg_read(2'd1, v); check("R10 transmit abort", v, 16'h30);
        check("R10 lines released", {30'd0, clk_pl, dat_pl}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule